// File: doc/BRIEF.md
# Flash security state controller

This block decides whether the device runs in the secured state. At reset it captures the security byte that the flash loader presents and keeps it. It also sets the secured flag from that byte alone. Any unlock granted earlier is forgotten at that point.

After reset, two events can clear the secured flag. The first is a backdoor key attempt, where the comparison of the eight key bytes against the stored keys is done outside this block and arrives as a single match bit. The second is a debug override bit, which the debug logic raises once the array has been verified erased. This override is honoured only in special single-chip mode.

A backdoor unlock lives only in this block's registers. It never changes the captured security byte, the stored keys or the program/erase protection settings. A key attempt that does not match disables the backdoor until the next reset.

Top module: `flash_sec_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block captures `sec_byte` into `sec_state`. It sets `secured` from that byte alone and clears any earlier unlock and any earlier key lockout. A key attempt presented in the same cycle as reset has no effect.
- R2: While `rst_n` stays high, `sec_state` never changes, whether or not an unlock or override has occurred.
- R3: After reset, `secured` is 0 when `sec_state[1:0]` equals 2'b10. Every other value of those two bits gives `secured` = 1.
- R4: `backdoor_en` is 1 only when all three of these hold: `sec_state[7:6]` equals 2'b10, `secured` is 1, and no mismatched attempt has been accepted since reset.
- R5: An accepted key attempt with `key_match` = 1 makes `secured` 0 at the next rising edge. The unlock holds until reset. An attempt is accepted when `key_attempt` = 1, `backdoor_en` = 1 and the attempt is not a debug-sourced request in special single-chip mode.
- R6: A key attempt with `key_via_dbg` = 1 while `mode_ssc` = 1 is ignored. It neither unlocks the device nor disables the backdoor.
- R7: With `mode_ssc` = 1 and `dbg_unsec` = 1, `secured` is 0 from the next rising edge, whatever the security byte holds. With `mode_ssc` = 0, `dbg_unsec` has no effect.
- R8: An accepted key attempt with `key_match` = 0 drives `backdoor_en` to 0 from the next rising edge. Later matching attempts then cannot unlock the device until reset.
- R9: Once the override condition is withdrawn, `secured` returns at the next rising edge to the value that the security byte and any backdoor unlock give. `secured` changes only at a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the security byte |
| sec_byte | input | 8 | Security byte from the flash loader, captured during reset |
| mode_ssc | input | 1 | 1 = special single-chip (debug) mode |
| key_attempt | input | 1 | One-cycle pulse: a backdoor key comparison has finished |
| key_match | input | 1 | Result of that comparison, 1 = all eight key bytes match |
| key_via_dbg | input | 1 | The attempt was requested through the debug interface |
| dbg_unsec | input | 1 | Debug override bit, set after an erase has been verified |
| secured | output | 1 | 1 = device secured |
| backdoor_en | output | 1 | 1 = a backdoor key attempt would currently be accepted |
| sec_state | output | 8 | Security byte captured at the last reset |

## Verification
The assertions assume that `key_attempt` is a single-cycle pulse and that `key_match` and `key_via_dbg` are meaningful only while it is high. They also assume that `sec_byte` only matters while reset is low. The bench drives each input at the falling edge and never holds an attempt pulse longer than one cycle. It changes the security byte only inside its reset task, and it samples outputs one falling edge after the rising edge that updates them.

// File: rtl/flash_sec_ctrl.sv
module flash_sec_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sec_byte,
  input  logic       mode_ssc,
  input  logic       key_attempt,
  input  logic       key_match,
  input  logic       key_via_dbg,
  input  logic       dbg_unsec,
  output logic       secured,
  output logic       backdoor_en,
  output logic [7:0] sec_state
);
  localparam logic [1:0] OPEN_CODE  = 2'b10;
  localparam logic [1:0] KEYEN_CODE = 2'b10;

  logic [7:0] sec_q;
  logic       secured_q, unlocked_q, blocked_q;
  logic       byte_open, keyen_ok, dbg_gate, try_ok, override;

  assign byte_open   = sec_q[1:0] == OPEN_CODE;
  assign keyen_ok    = sec_q[7:6] == KEYEN_CODE;
  assign dbg_gate    = mode_ssc & key_via_dbg;
  assign override    = mode_ssc & dbg_unsec;
  assign backdoor_en = keyen_ok & secured_q & ~blocked_q;
  assign try_ok      = key_attempt & backdoor_en & ~dbg_gate;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q      <= sec_byte;
      unlocked_q <= 1'b0;
      blocked_q  <= 1'b0;
      secured_q  <= sec_byte[1:0] != OPEN_CODE;
    end else begin
      if (try_ok &&  key_match) unlocked_q <= 1'b1;
      if (try_ok && !key_match) blocked_q  <= 1'b1;
      secured_q <= ~(byte_open | unlocked_q | (try_ok & key_match) | override);
    end
  end

  assign secured   = secured_q;
  assign sec_state = sec_q;
endmodule

module flash_sec_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_ssc,
  input logic       key_attempt,
  input logic       key_match,
  input logic       key_via_dbg,
  input logic       dbg_unsec,
  input logic       secured,
  input logic       backdoor_en,
  input logic [7:0] sec_state
);
  a_r2_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(sec_state));

  a_r3_open_code: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_state[1:0] == 2'b10) |-> !secured);

  a_r4_needs_secured: assert property (@(posedge clk) disable iff (!rst_n)
    backdoor_en |-> (secured && sec_state[7:6] == 2'b10));

  a_r5_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (key_attempt && key_match && backdoor_en && !(mode_ssc && key_via_dbg)) |=> !secured);

  a_r6_dbg_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (key_attempt && mode_ssc && key_via_dbg && !dbg_unsec && secured
     && sec_state[1:0] != 2'b10) |=> (secured && $stable(backdoor_en)));

  a_r7_override: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ssc && dbg_unsec) |=> !secured);

  a_r8_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    (key_attempt && !key_match && backdoor_en && !(mode_ssc && key_via_dbg)) |=> !backdoor_en);
endmodule

bind flash_sec_ctrl flash_sec_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_ssc(mode_ssc), .key_attempt(key_attempt),
  .key_match(key_match), .key_via_dbg(key_via_dbg), .dbg_unsec(dbg_unsec),
  .secured(secured), .backdoor_en(backdoor_en), .sec_state(sec_state));

// File: tb/flash_sec_ctrl_bench.sv
module flash_sec_ctrl_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] sec_byte = 8'hFF;
  logic mode_ssc = 1'b0, key_attempt = 1'b0, key_match = 1'b0;
  logic key_via_dbg = 1'b0, dbg_unsec = 1'b0;
  logic secured, backdoor_en;
  logic [7:0] sec_state;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_sec_ctrl u_flash_sec_ctrl (
    .clk(clk), .rst_n(rst_n), .sec_byte(sec_byte), .mode_ssc(mode_ssc),
    .key_attempt(key_attempt), .key_match(key_match), .key_via_dbg(key_via_dbg),
    .dbg_unsec(dbg_unsec), .secured(secured), .backdoor_en(backdoor_en),
    .sec_state(sec_state));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [7:0] b, bit with_try = 1'b0);
    @(negedge clk);
    rst_n = 1'b0; sec_byte = b;
    key_attempt = with_try; key_match = 1'b1; key_via_dbg = 1'b0;
    @(negedge clk);
    key_attempt = 1'b0;
    rst_n = 1'b1; sec_byte = ~b;
  endtask

  task automatic attempt(bit match, bit via_dbg);
    key_attempt = 1'b1; key_match = match; key_via_dbg = via_dbg;
    @(negedge clk);
    key_attempt = 1'b0; key_match = 1'b0; key_via_dbg = 1'b0;
  endtask

  task automatic t_reset_state;
    do_reset(8'hFF);
    chk("R1 byte captured", sec_state, 8'hFF);
    chk("R3 secured FF", {7'd0, secured}, 8'd1);
    chk("R4 keyen 11 no backdoor", {7'd0, backdoor_en}, 8'd0);
    do_reset(8'hFE);
    chk("R3 open code 10", {7'd0, secured}, 8'd0);
  endtask

  task automatic t_unlock;
    do_reset(8'h81);
    chk("R4 backdoor enabled", {7'd0, backdoor_en}, 8'd1);
    attempt(1'b1, 1'b0);
    chk("R5 unlocked", {7'd0, secured}, 8'd0);
    chk("R2 byte unchanged", sec_state, 8'h81);
    repeat (3) @(negedge clk);
    chk("R5 unlock holds", {7'd0, secured}, 8'd0);
    do_reset(8'h81);
    chk("R1 unlock lost", {7'd0, secured}, 8'd1);
  endtask

  task automatic t_dbg_ignored;
    do_reset(8'h81);
    mode_ssc = 1'b1;
    attempt(1'b1, 1'b1);
    chk("R6 dbg attempt ignored", {7'd0, secured}, 8'd1);
    attempt(1'b0, 1'b1);
    chk("R6 dbg mismatch no lockout", {7'd0, backdoor_en}, 8'd1);
    mode_ssc = 1'b0;
  endtask

  task automatic t_lockout;
    do_reset(8'h81);
    attempt(1'b0, 1'b0);
    chk("R8 backdoor off", {7'd0, backdoor_en}, 8'd0);
    attempt(1'b1, 1'b0);
    chk("R8 later match refused", {7'd0, secured}, 8'd1);
    do_reset(8'h81);
    chk("R1 lockout cleared", {7'd0, backdoor_en}, 8'd1);
  endtask

  task automatic t_override;
    do_reset(8'hFF);
    dbg_unsec = 1'b1;
    @(negedge clk);
    chk("R7 normal mode no effect", {7'd0, secured}, 8'd1);
    mode_ssc = 1'b1;
    @(negedge clk);
    chk("R7 override unsecures", {7'd0, secured}, 8'd0);
    chk("R2 byte unchanged", sec_state, 8'hFF);
    dbg_unsec = 1'b0;
    @(negedge clk);
    chk("R9 override withdrawn", {7'd0, secured}, 8'd1);
    mode_ssc = 1'b0;
  endtask

  task automatic t_reset_drop;
    do_reset(8'h81, 1'b1);
    chk("R1 attempt in reset dropped", {7'd0, secured}, 8'd1);
    do_reset(8'h01);
    attempt(1'b1, 1'b0);
    chk("R4 keyen 00 refuses", {7'd0, secured}, 8'd1);
  endtask

  initial begin
    t_reset_state();
    t_unlock();
    t_dbg_ignored();
    t_lockout();
    t_override();
    t_reset_drop();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule